// File: doc/BRIEF.md
# Minimum-Gap Frame Pacer

The pacer sits between one virtual channel's frame source and a scheduler that multiplexes several channels onto a link. Frame descriptors (a length and a channel identifier) arrive on a valid/ready input. The pacer stores them in a small queue. It lets each one out on a valid/ready output only when the previous release lies at least one configured minimum gap in the past. A frame that arrives early waits; it is never thrown away for being early.

The gap is chosen by a 3-bit exponent code and always equals a power-of-two number of milliseconds. Time is counted in clock cycles, built from a cycles-per-microsecond parameter and a microseconds-per-millisecond parameter, so every release is spaced by the full gap. A consumer further down the link may accept spacing that is shorter by its own jitter allowance, but the pacer itself never relies on that allowance. Each descriptor is checked against a configured maximum length when it is accepted. A descriptor longer than that limit is reported on a one-cycle flag and is not queued.

Top module: `frame_pacer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid and oversize_flag are 0 and in_ready is 1.
- R2: The gap code g (0 to 7) selects a gap of 2^g ms, which is 2^g × US_PER_MS × CYC_PER_US clock cycles. Two consecutive release edges (out_valid and out_ready both high at a rising edge) are never fewer than that many cycles apart. The gap used is the one latched at the earlier of the two releases.
- R3: A queued frame that is held by the gap is not dropped. out_valid rises in the cycle just before the edge that lies exactly one gap after the previous release, so the next release can happen on that edge.
- R4: After reset, or once the gap since the last release has run out while the queue was empty, a newly accepted frame is offered on out_valid in the cycle right after its acceptance edge.
- R5: A descriptor accepted with in_len greater than cfg_max_len is not queued, and oversize_flag is 1 for exactly the cycle after its acceptance edge. A descriptor with in_len equal to cfg_max_len is queued normally.
- R6: The queue holds DEPTH (default 4) descriptors. in_ready is 0 exactly when DEPTH descriptors are queued. Descriptors leave in arrival order, with length and channel identifier unchanged.
- R7: A change of cfg_gap_code while a gap is being timed does not affect that gap. The new code applies from the next release on.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_len and out_chan hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gap_code | input | 3 | Gap exponent: the gap is 2^code ms |
| cfg_max_len | input | LEN_W | Largest permitted frame length |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Queue can take a descriptor |
| in_len | input | LEN_W | Frame length of the input descriptor |
| in_chan | input | CHAN_W | Channel identifier of the input descriptor |
| out_valid | output | 1 | Head descriptor may be released now |
| out_ready | input | 1 | Scheduler takes the offered descriptor |
| out_len | output | LEN_W | Frame length of the released descriptor |
| out_chan | output | CHAN_W | Channel identifier of the released descriptor |
| oversize_flag | output | 1 | One-cycle pulse for a rejected over-length descriptor |

## Verification
The assertions assume that cfg_max_len does not change while descriptors are queued, since the bound on out_len is measured against its current value. They also assume that the scheduler keeps out_ready stable on its own, without waiting on any other output. The stimulus keeps the length limit fixed for the whole run and drives out_ready from a pattern that does not look at the pacer. It changes the gap code freely, including in the middle of a gap, which covers deferred code changes, long 128 ms gaps and idle periods long enough for a gap to run out.

// File: rtl/frame_pacer.sv
module frame_pacer #(
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int LEN_W      = 11,
  parameter int CHAN_W     = 16,
  parameter int DEPTH      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_gap_code,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [CHAN_W-1:0] in_chan,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  out_len,
  output logic [CHAN_W-1:0] out_chan,
  output logic              oversize_flag
);
  localparam int CPM   = CYC_PER_US * US_PER_MS;
  localparam int PRE_W = (CPM > 1) ? $clog2(CPM) : 1;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LEN_W-1:0]  q_len  [DEPTH];
  logic [CHAN_W-1:0] q_chan [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  count;

  logic             open_q;
  logic [PRE_W-1:0] pre;
  logic [7:0]       ms;
  logic [2:0]       code_q;
  logic [7:0]       gap_last;

  logic accept, too_long, push, pop, expiring;

  assign accept   = in_valid && in_ready;
  assign too_long = in_len > cfg_max_len;
  assign push     = accept && !too_long;
  assign pop      = out_valid && out_ready;
  assign gap_last = (8'd1 << code_q) - 8'd1;
  assign expiring = !open_q && (pre == PRE_W'(CPM - 1)) && (ms == gap_last);

  assign in_ready  = count != CNT_W'(DEPTH);
  assign out_valid = (count != '0) && (open_q || expiring);
  assign out_len   = q_len[rd_ptr];
  assign out_chan  = q_chan[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b1;
      pre    <= '0;
      ms     <= '0;
      code_q <= '0;
    end else if (pop) begin
      open_q <= 1'b0;
      pre    <= '0;
      ms     <= '0;
      code_q <= cfg_gap_code;
    end else if (!open_q) begin
      if (pre == PRE_W'(CPM - 1)) begin
        pre <= '0;
        if (ms == gap_last) open_q <= 1'b1;
        else                ms     <= ms + 8'd1;
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_len[wr_ptr]  <= in_len;
      q_chan[wr_ptr] <= in_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr        <= '0;
      wr_ptr        <= '0;
      count         <= '0;
      oversize_flag <= 1'b0;
    end else begin
      oversize_flag <= accept && too_long;
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/frame_pacer_chk.sv
module frame_pacer_chk #(
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int LEN_W      = 11,
  parameter int CHAN_W     = 16,
  parameter int DEPTH      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cfg_gap_code,
  input logic [LEN_W-1:0]  cfg_max_len,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LEN_W-1:0]  in_len,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LEN_W-1:0]  out_len,
  input logic [CHAN_W-1:0] out_chan,
  input logic              oversize_flag
);
  localparam int CPM = CYC_PER_US * US_PER_MS;

  logic        rel, acc_ok, have;
  logic [31:0] since, need;
  int          occ;

  assign rel    = out_valid && out_ready;
  assign acc_ok = in_valid && in_ready && (in_len <= cfg_max_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have  <= 1'b0;
      since <= '0;
      need  <= '0;
      occ   <= 0;
    end else begin
      occ <= occ + int'(acc_ok) - int'(rel);
      if (rel) begin
        have  <= 1'b1;
        since <= 32'd1;
        need  <= (32'd1 << cfg_gap_code) * 32'(CPM);
      end else if (since != '1) begin
        since <= since + 32'd1;
      end
    end
  end

  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> (!have || since >= need)); // R2
  AST_READY_MATCHES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (occ < DEPTH)); // R6
  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 0) |-> !out_valid); // R3
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_chan))); // R8
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    oversize_flag |-> $past(in_valid && in_ready && (in_len > cfg_max_len))); // R5
  AST_NO_LONG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len <= cfg_max_len)); // R5
endmodule

bind frame_pacer frame_pacer_chk #(
  .CYC_PER_US(CYC_PER_US), .US_PER_MS(US_PER_MS),
  .LEN_W(LEN_W), .CHAN_W(CHAN_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_gap_code(cfg_gap_code), .cfg_max_len(cfg_max_len),
  .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len),
  .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
  .out_chan(out_chan), .oversize_flag(oversize_flag)
);

// File: tb/tb_frame_pacer.sv
module tb_frame_pacer;
  localparam int CUS = 2;
  localparam int UPM = 4;
  localparam int CPM = CUS * UPM;
  localparam int LW  = 11;
  localparam int CW  = 8;
  localparam int DEP = 4;
  localparam int MAXL = 100;
  localparam int RUN  = 16000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]    cfg_gap_code = '0;
  logic [LW-1:0] cfg_max_len = LW'(MAXL);
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [LW-1:0] in_len = '0;
  logic [CW-1:0] in_chan = '0;
  logic in_ready, out_valid, oversize_flag;
  logic [LW-1:0] out_len;
  logic [CW-1:0] out_chan;

  always #5 clk = ~clk;

  frame_pacer #(.CYC_PER_US(CUS), .US_PER_MS(UPM), .LEN_W(LW), .CHAN_W(CW), .DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_gap_code(cfg_gap_code), .cfg_max_len(cfg_max_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len), .in_chan(in_chan),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_chan(out_chan),
    .oversize_flag(oversize_flag));

  int vectors = 0, errs = 0;
  int mq_len[$];
  int mq_chan[$];
  bit have = 0, exp_flag = 0, code_moved = 0, stalled = 0;
  int last = 0, gap = 0, e = 0, seq = 0;
  bit [2:0] code_at_rel = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, e);
    end
  endtask

  task automatic step(int c);
    bit mvalid, rel, acc;
    int r;
    mvalid = (mq_len.size() > 0) && (!have || (e + 1 - last) >= gap);
    chk("R6 in_ready", int'(in_ready), int'(mq_len.size() < DEP));
    chk(!have ? "R4 out_valid" : (code_moved ? "R7 out_valid" : "R3 out_valid"),
        int'(out_valid), int'(mvalid));
    if (mvalid) begin
      chk(stalled ? "R8 out_len" : "R6 out_len", int'(out_len), mq_len[0]);
      chk(stalled ? "R8 out_chan" : "R6 out_chan", int'(out_chan), mq_chan[0]);
    end
    chk("R5 oversize_flag", int'(oversize_flag), int'(exp_flag));

    if (c < 3000)       cfg_gap_code = 3'd0;
    else if (c < 6000)  cfg_gap_code = 3'd2;
    else if (c < 9000)  cfg_gap_code = 3'((c / 150) % 4);
    else if (c < 12000) cfg_gap_code = 3'd7;
    else                cfg_gap_code = 3'd1;

    if (c < 3000)      out_ready = 1'b1;
    else if (c < 6000) out_ready = 1'($urandom % 2);
    else if (c < 9000) out_ready = ((c / 40) % 3) != 0;
    else               out_ready = ($urandom % 4) != 0;

    if (c >= 12000 && c < 13000) in_valid = 1'b0;
    else if (c >= 9000 && c < 12000) in_valid = 1'($urandom % 2);
    else in_valid = ($urandom % 3) == 0;
    r = $urandom % 8;
    if (r == 0)      in_len = LW'(MAXL);
    else if (r == 1) in_len = LW'(MAXL + 1);
    else if (r == 2) in_len = LW'(MAXL + 1 + $urandom % 20);
    else             in_len = LW'($urandom % MAXL);
    seq++;
    in_chan = CW'(seq);

    acc = in_valid && (mq_len.size() < DEP);
    rel = mvalid && out_ready;
    stalled = mvalid && !out_ready;
    if (rel) begin
      if (have) chk("R2 spacing", int'((e + 1 - last) >= gap), 1);
      void'(mq_len.pop_front());
      void'(mq_chan.pop_front());
      have = 1;
      last = e + 1;
      gap = (1 << cfg_gap_code) * CPM;
      code_at_rel = cfg_gap_code;
    end
    code_moved = have && (cfg_gap_code != code_at_rel);
    exp_flag = acc && (int'(in_len) > MAXL);
    if (acc && int'(in_len) <= MAXL) begin
      mq_len.push_back(int'(in_len));
      mq_chan.push_back(int'(in_chan));
    end
    e++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 oversize_flag", int'(oversize_flag), 0);
    rst_n = 1'b1;
    for (int c = 0; c < RUN; c++) begin
      if (c > 0) @(negedge clk);
      step(c);
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #5_000_000;
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule